// File: doc/BRIEF.md
# Serial-programmed digital potentiometer control core

This block is the digital side of a single-channel digital potentiometer. A host writes a wiper code over a three-wire serial link made of an active-low select, a serial clock and a data line. While the select is low, each rising serial-clock edge shifts one data bit into a shift register, most significant bit first. When the select goes high, the captured word is moved into the wiper latch. The registered tap index that drives the resistor switch array is taken from that latch.

One parameter sets the number of wiper positions. With 256 positions the word is 8 bits wide. With 33 positions the word is 6 bits wide, and codes above full scale are clamped. Reset loads a midscale code. An active-low shutdown input opens the A-terminal switch and shorts the wiper to B. During shutdown the latch still accepts writes, and the wiper returns to whatever code the latch holds when shutdown ends.

All serial and shutdown inputs are treated as asynchronous. They pass through two-flop synchronizers into the block clock domain before use.

Top module: `digipot_core`

## Requirements
- R1: After reset the tap index is midscale: 0x80 with 256 positions, 0x10 with 33 positions. With shutdown inactive, the shutdown flag, the A-open output and the wiper-to-B output are all 0.
- R2: While `cs_n` is low, each rising `sclk` edge shifts `sdi` in MSB first. A rising edge on `cs_n` transfers the captured word to the latch and to `tap_code`.
- R3: When more bits are clocked than the word width (8 with 256 positions, 6 with 33 positions), only the last word-width bits before `cs_n` rises are kept.
- R4: A `cs_n` low/high pulse with no rising `sclk` edge in between leaves the latch and `tap_code` unchanged.
- R5: Rising `sclk` edges while `cs_n` is high have no effect on the latch or `tap_code`.
- R6: With 33 positions, a received code above 32 (0x20) is latched as 32. Codes 0 through 32 pass unchanged.
- R7: While `shdn_n` is low, `shut_flag`, `term_a_open` and `wiper_b_short` are 1 and `tap_code` is 0.
- R8: Writes made during shutdown update the latch. When `shdn_n` returns high, `tap_code` shows the latch value, which is either the last write or the pre-shutdown code.
- R9: Outputs are registered and change only on a latch transfer or a shutdown change. Each such change appears on the third rising `clk` edge after the causing input change, and not on the second.
- R10: A frame of k rising `sclk` edges, with k below the word width, latches those k bits as the low bits of the code, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low; rising edge loads the latch |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| shdn_n | input | 1 | Shutdown request, active low |
| tap_code | output | WORD_W | Registered wiper tap index (8 or 6 bits) |
| shut_flag | output | 1 | High while shutdown is in force |
| term_a_open | output | 1 | Opens the A-terminal switch |
| wiper_b_short | output | 1 | Shorts the wiper to terminal B |

## Verification
Every input passes through two synchronizer flops, and one further register holds the result. A `cs_n` rise, and likewise a `shdn_n` change, therefore reaches the outputs on the third rising `clk` edge after the bench drives it. The bench drives inputs 1 ns after a clock edge. It samples once after two edges to confirm the old value still holds, and again after the third edge for the new value. The serial data line is set one clock before each `sclk` rise and held past its fall, so the synchronized data and the synchronized edge line up.

// File: rtl/digipot_core.sv
module digipot_core #(
  parameter int POSITIONS = 256
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cs_n,
  input  logic                                  sclk,
  input  logic                                  sdi,
  input  logic                                  shdn_n,
  output logic [$clog2(POSITIONS)-1:0]          tap_code,
  output logic                                  shut_flag,
  output logic                                  term_a_open,
  output logic                                  wiper_b_short
);
  localparam int WORD_W   = $clog2(POSITIONS);
  localparam int MAX_CODE = POSITIONS - 1;
  localparam int MID_CODE = POSITIONS / 2;
  localparam logic [WORD_W-1:0] MAX_W = WORD_W'(MAX_CODE);
  localparam logic [WORD_W-1:0] MID_W = WORD_W'(MID_CODE);

  logic [2:0] cs_sy, sclk_sy;
  logic [1:0] sdi_sy, sd_sy;
  logic [WORD_W-1:0] shreg, latch_q, latch_d, clamped;
  logic got_bit, sd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy   <= 3'b111;
      sclk_sy <= 3'b000;
      sdi_sy  <= 2'b00;
      sd_sy   <= 2'b11;
    end else begin
      cs_sy   <= {cs_sy[1:0], cs_n};
      sclk_sy <= {sclk_sy[1:0], sclk};
      sdi_sy  <= {sdi_sy[0], sdi};
      sd_sy   <= {sd_sy[0], shdn_n};
    end

  wire cs_fall   = !cs_sy[1] &&  cs_sy[2];
  wire cs_rise   =  cs_sy[1] && !cs_sy[2];
  wire sclk_rise =  sclk_sy[1] && !sclk_sy[2];
  wire sd_next   = !sd_sy[1];
  wire load      = cs_rise && got_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      got_bit <= 1'b0;
    end else if (cs_fall) begin
      shreg   <= '0;
      got_bit <= 1'b0;
    end else if (sclk_rise && !cs_sy[1]) begin
      shreg   <= {shreg[WORD_W-2:0], sdi_sy[1]};
      got_bit <= 1'b1;
    end

  generate
    if (POSITIONS == (1 << WORD_W)) begin : g_full
      assign clamped = shreg;
    end else begin : g_clamp
      assign clamped = (shreg > MAX_W) ? MAX_W : shreg;
    end
  endgenerate

  assign latch_d = load ? clamped : latch_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      latch_q  <= MID_W;
      tap_code <= MID_W;
      sd_q     <= 1'b0;
    end else begin
      latch_q  <= latch_d;
      tap_code <= sd_next ? '0 : latch_d;
      sd_q     <= sd_next;
    end

  assign shut_flag     = sd_q;
  assign term_a_open   = sd_q;
  assign wiper_b_short = sd_q;

  AST_LATCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q <= MAX_W);                                            // R6
  AST_NO_EDGE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !got_bit) |=> $stable(latch_q));                  // R4
  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && cs_sy[1]) |=> $stable(shreg));                  // R5
  AST_SD_TAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    shut_flag |-> (tap_code == '0 && term_a_open && wiper_b_short)); // R7
  AST_RELEASE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shut_flag) |-> tap_code == latch_q);                    // R8
  AST_TAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_rise && (sd_q == sd_next)) |=> $stable(tap_code));       // R9
endmodule

// File: tb/sim_digipot_core.sv
module sim_digipot_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, shdn_n = 1'b1;
  logic [7:0] tap0;
  logic [5:0] tap1;
  logic sf0, ao0, wb0, sf1, ao1, wb1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  digipot_core #(.POSITIONS(256)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .shdn_n(shdn_n),
    .tap_code(tap0), .shut_flag(sf0), .term_a_open(ao0), .wiper_b_short(wb0));
  digipot_core #(.POSITIONS(33)) u1 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .shdn_n(shdn_n),
    .tap_code(tap1), .shut_flag(sf1), .term_a_open(ao1), .wiper_b_short(wb1));

  // {word sent as 8 bits, expected 256-position code, expected 33-position code}
  localparam logic [23:0] VECS [8] = '{
    {8'h00, 8'h00, 8'h00}, {8'hFF, 8'hFF, 8'h20}, {8'hA5, 8'hA5, 8'h20},
    {8'h5A, 8'h5A, 8'h1A}, {8'h20, 8'h20, 8'h20}, {8'h1F, 8'h1F, 8'h1F},
    {8'h21, 8'h21, 8'h20}, {8'h01, 8'h01, 8'h01}};

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_bits(logic [7:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      tick(1);
      sclk = 1'b1;
      tick(2);
      sclk = 1'b0;
      tick(1);
    end
  endtask

  // frame, then old value after two edges, new value after the third
  task automatic frame(string req, logic [7:0] w, int n, logic [7:0] e0, logic [7:0] e1);
    logic [7:0] old0, old1;
    old0 = tap0;
    old1 = {2'b00, tap1};
    cs_n = 1'b0;
    tick(3);
    shift_bits(w, n);
    cs_n = 1'b1;
    tick(2);
    check({req, " R9 early u0"}, tap0, old0);
    check({req, " R9 early u1"}, {2'b00, tap1}, old1);
    tick(1);
    check({req, " u0"}, tap0, e0);
    check({req, " u1"}, {2'b00, tap1}, e1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check("R1 midscale 256", tap0, 8'h80);
    check("R1 midscale 33", {2'b00, tap1}, 8'h10);
    check("R1 flags", {5'b0, sf0, ao0, wb0}, 8'h00);
    check("R1 flags 33", {5'b0, sf1, ao1, wb1}, 8'h00);

    for (int v = 0; v < 8; v++)
      frame("R2 R3 R6 table", VECS[v][23:16], 8, VECS[v][15:8], VECS[v][7:0]);

    frame("R6 R10 six bits 0x20", 8'h20, 6, 8'h20, 8'h20);
    frame("R6 R10 six bits 0x3F", 8'h3F, 6, 8'h3F, 8'h20);
    frame("R10 short frame", 8'h05, 3, 8'h05, 8'h05);
    frame("R3 long frame", 8'hC3, 8, 8'hC3, 8'h03);

    cs_n = 1'b0;
    tick(4);
    cs_n = 1'b1;
    tick(4);
    check("R4 empty frame u0", tap0, 8'hC3);
    check("R4 empty frame u1", {2'b00, tap1}, 8'h03);

    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; tick(3); sclk = 1'b0; tick(3);
    end
    check("R5 idle sclk u0", tap0, 8'hC3);
    check("R5 idle sclk u1", {2'b00, tap1}, 8'h03);

    shdn_n = 1'b0;
    tick(2);
    check("R9 shutdown early", {7'b0, sf0}, 8'h00);
    tick(1);
    check("R7 shut flag", {5'b0, sf0, ao0, wb0}, 8'h07);
    check("R7 shut flag 33", {5'b0, sf1, ao1, wb1}, 8'h07);
    check("R7 tap zero u0", tap0, 8'h00);
    check("R7 tap zero u1", {2'b00, tap1}, 8'h00);
    frame("R8 write in shutdown", 8'h3C, 8, 8'h00, 8'h00);
    shdn_n = 1'b1;
    tick(2);
    check("R9 release early", tap0, 8'h00);
    tick(1);
    check("R8 release u0", tap0, 8'h3C);
    check("R8 release u1", {2'b00, tap1}, 8'h20);
    check("R7 flags cleared", {5'b0, sf0, ao0, wb0}, 8'h00);

    shdn_n = 1'b0;
    tick(5);
    check("R7 tap zero again", tap0, 8'h00);
    shdn_n = 1'b1;
    tick(3);
    check("R8 pre-shutdown code u0", tap0, 8'h3C);
    check("R8 pre-shutdown code u1", {2'b00, tap1}, 8'h20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule